// File: doc/BRIEF.md
# Indexed Display Register Interface

This block is the host-side register file of a small 2D display controller. The host reaches it through two ports of a narrow I/O window. It first writes a register number to the index port. It then reads or writes the selected register through the value port. A third, auxiliary port reads as zero and discards writes. Read data is combinational: it is valid in the same cycle as the read strobe.

The register file does the following:
- Accepts a controller identity, but only when the host offers one of three fixed version codes.
- Runs the configuration and enable handshake.
- Holds the pending mode (width and height) and checks the host's colour depth against the fixed one.
- Serves values derived from that depth and from the memory sizes, without storing them.
- Keeps the cursor state and a parameterised bank of scratch words.

Writes to the configuration-done register and to the sync register each raise a one-cycle strobe toward the command engine. Reading the busy register reports whether that engine is idle.

Top module: `dispctl_regfile`

## Requirements
- R1: The index port (port 0) stores the low 16 bits of a written value and reads them back. The auxiliary port (port 2) reads zero, and a write to it changes nothing.
- R2: Register 0 (identity) reads 0x90000002 after reset. A write of 0x90000000, 0x90000001 or 0x90000002 is stored. Any other value leaves the stored identity unchanged.
- R3: A write to register 1 (enable) sets both the enable flag and the config flag to bit 0 of the value ANDed with the current config flag. Register 1 and `enable_o` show the enable flag.
- R4: A write to register 20 sets the config flag to bit 0 of the value, and register 20 reads that flag back. A write to register 20 pulses `cfg_stb_o` in the following cycle. A write to register 21 pulses `sync_stb_o` in the following cycle.
- R5: Register 22 (busy) reads 1 while `engine_idle_i` is low and 0 while it is high.
- R6: Registers 2 and 3 store the low 16 bits of the pending width and height. Registers 7 and 28 read the depth rounded up to a multiple of 8. Register 12 reads ((depth+7)>>3) times the pending width.
- R7: A write to register 7 with a value other than the fixed depth pulses `depth_err_o` in the following cycle. A write of the fixed depth raises no pulse.
- R8: Register 27 (cursor visible) takes three kinds of value. A write of 1 sets the flag and a write of 0 clears it. Any value of 2 or more leaves the flag unchanged. The flag drives `cursor_on_o`.
- R9: The following read-only registers return constants and ignore writes:

  | Register | Reads |
  |---|---|
  | 4 | 2360 |
  | 5 | 1770 |
  | 6 | the depth |
  | 15 | total memory minus 0x10000 |
  | 17 | bit 0 = fill capability, bit 1 = copy capability |
  | 19 | 0x10000 |
  | 29 | the scratch count |
- R10: Registers 30 to 32 and the palette range 1024 to 1791 read zero, ignore writes, and raise no error.
- R11: Scratch word k sits at index 1792+k for k below the scratch count. It stores a written value and reads it back.
- R12: A value-port access to any other index reads zero, changes nothing, and pulses `bad_index_o` in the following cycle. The indices 8 to 11, 13, 14, 16, 18, 23, 1023 and 1792+count are among them.
- R13: Registers 24, 25 and 26 (cursor id, x, y) store full 32-bit values and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| port_i | input | 2 | 0 index, 1 value, 2 auxiliary |
| wdata_i | input | 32 | Host write data |
| engine_idle_i | input | 1 | Command engine is idle |
| rdata_o | output | 32 | Read data, valid while rd_i is high |
| enable_o | output | 1 | Enable flag |
| cursor_on_o | output | 1 | Cursor visible flag |
| cfg_stb_o | output | 1 | Config-done write strobe |
| sync_stb_o | output | 1 | Sync write strobe |
| bad_index_o | output | 1 | Access to an undefined index |
| depth_err_o | output | 1 | Rejected depth write |

## Verification
The bench targets the enable/config ordering:
- An enable write made before any config-done write must give zero. A design that ignored the AND would enable at once.
- An enable write with bit 0 clear must drop both flags.

Identity writes with near-miss values must be discarded. Cursor codes 2 and 3 must hold the flag, where a naive decoder would treat them as show or hide. The scratch boundary at the last slot and one past it separates an off-by-one range check from a correct one. Palette and reserved reads separate "zero without error" from "zero with error".

// File: rtl/dreg_pkg.sv
package dreg_pkg;
  localparam logic [31:0] ID_V0 = 32'h9000_0000;
  localparam logic [31:0] ID_V1 = 32'h9000_0001;
  localparam logic [31:0] ID_V2 = 32'h9000_0002;

  localparam int unsigned IX_ID    = 0;
  localparam int unsigned IX_EN    = 1;
  localparam int unsigned IX_W     = 2;
  localparam int unsigned IX_H     = 3;
  localparam int unsigned IX_MAXW  = 4;
  localparam int unsigned IX_MAXH  = 5;
  localparam int unsigned IX_DEPTH = 6;
  localparam int unsigned IX_BPP   = 7;
  localparam int unsigned IX_BPL   = 12;
  localparam int unsigned IX_VRAM  = 15;
  localparam int unsigned IX_CAPS  = 17;
  localparam int unsigned IX_FIFO  = 19;
  localparam int unsigned IX_CFG   = 20;
  localparam int unsigned IX_SYNC  = 21;
  localparam int unsigned IX_BUSY  = 22;
  localparam int unsigned IX_CID   = 24;
  localparam int unsigned IX_CX    = 25;
  localparam int unsigned IX_CY    = 26;
  localparam int unsigned IX_CON   = 27;
  localparam int unsigned IX_HBPP  = 28;
  localparam int unsigned IX_SCRN  = 29;
  localparam int unsigned IX_RSV_LO = 30;
  localparam int unsigned IX_RSV_HI = 32;
  localparam int unsigned IX_PAL_LO = 1024;
  localparam int unsigned IX_PAL_HI = 1791;
  localparam int unsigned IX_SCR    = 1792;

  localparam logic [1:0] PORT_IDX = 2'd0;
  localparam logic [1:0] PORT_VAL = 2'd1;

  typedef enum logic [4:0] {
    K_ID, K_EN, K_W, K_H, K_MAXW, K_MAXH, K_DEPTH, K_BPP, K_BPL, K_VRAM,
    K_CAPS, K_FIFO, K_CFG, K_SYNC, K_BUSY, K_CID, K_CX, K_CY, K_CON,
    K_HBPP, K_SCRN, K_ZERO, K_SCR, K_BAD
  } kind_e;
endpackage

// File: rtl/dreg_decode.sv
module dreg_decode import dreg_pkg::*; #(
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned SCR_N  = 16,
  parameter int unsigned SCR_AW = 4
) (
  input  logic [IDX_W-1:0]  idx_i,
  output kind_e             kind_o,
  output logic [SCR_AW-1:0] scr_off_o
);
  int unsigned iv;
  int unsigned rel;

  always_comb begin
    iv        = 32'(idx_i);
    rel       = iv - IX_SCR;
    scr_off_o = rel[SCR_AW-1:0];
    case (iv)
      IX_ID:    kind_o = K_ID;
      IX_EN:    kind_o = K_EN;
      IX_W:     kind_o = K_W;
      IX_H:     kind_o = K_H;
      IX_MAXW:  kind_o = K_MAXW;
      IX_MAXH:  kind_o = K_MAXH;
      IX_DEPTH: kind_o = K_DEPTH;
      IX_BPP:   kind_o = K_BPP;
      IX_BPL:   kind_o = K_BPL;
      IX_VRAM:  kind_o = K_VRAM;
      IX_CAPS:  kind_o = K_CAPS;
      IX_FIFO:  kind_o = K_FIFO;
      IX_CFG:   kind_o = K_CFG;
      IX_SYNC:  kind_o = K_SYNC;
      IX_BUSY:  kind_o = K_BUSY;
      IX_CID:   kind_o = K_CID;
      IX_CX:    kind_o = K_CX;
      IX_CY:    kind_o = K_CY;
      IX_CON:   kind_o = K_CON;
      IX_HBPP:  kind_o = K_HBPP;
      IX_SCRN:  kind_o = K_SCRN;
      default: begin
        if ((iv >= IX_RSV_LO && iv <= IX_RSV_HI) ||
            (iv >= IX_PAL_LO && iv <= IX_PAL_HI))
          kind_o = K_ZERO;
        else if (iv >= IX_SCR && rel < SCR_N)
          kind_o = K_SCR;
        else
          kind_o = K_BAD;
      end
    endcase
  end
endmodule

// File: rtl/dreg_scratch.sv
module dreg_scratch #(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem[g] <= '0;
      else if (we_i && off_i == AW'(g))        mem[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (off_i == AW'(i)) rdata_o = mem[i];
  end

  // R11: a write lands in the addressed slot
  a_r11_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == $past(wdata_i) || off_i != $past(off_i));
endmodule

// File: rtl/dreg_cursor.sv
module dreg_cursor (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_id_i,
  input  logic        we_x_i,
  input  logic        we_y_i,
  input  logic        we_on_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] id_o,
  output logic [31:0] x_o,
  output logic [31:0] y_o,
  output logic        on_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o <= '0;
      x_o  <= '0;
      y_o  <= '0;
      on_o <= 1'b0;
    end else begin
      if (we_id_i) id_o <= wdata_i;
      if (we_x_i)  x_o  <= wdata_i;
      if (we_y_i)  y_o  <= wdata_i;
      // 0 hides, 1 shows, anything else keeps
      if (we_on_i && wdata_i == 32'd1) on_o <= 1'b1;
      else if (we_on_i && wdata_i == 32'd0) on_o <= 1'b0;
    end
  end

  a_r8_show_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_on_i && wdata_i == 32'd1) |=> on_o);
  a_r8_hide_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_on_i && wdata_i == 32'd0) |=> !on_o);
  a_r8_other_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_on_i && wdata_i > 32'd1) |=> on_o == $past(on_o));
endmodule

// File: rtl/dispctl_regfile.sv
module dispctl_regfile import dreg_pkg::*; #(
  parameter int unsigned DEPTH      = 24,
  parameter int unsigned VRAM_BYTES = 32'h0100_0000,
  parameter int unsigned FIFO_BYTES = 32'h0001_0000,
  parameter int unsigned MAX_W      = 2360,
  parameter int unsigned MAX_H      = 1770,
  parameter int unsigned SCR_N      = 16,
  parameter int unsigned IDX_W      = 16,
  parameter int unsigned DIM_W      = 16,
  parameter bit          CAP_FILL   = 1'b1,
  parameter bit          CAP_COPY   = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [1:0]  port_i,
  input  logic [31:0] wdata_i,
  input  logic        engine_idle_i,
  output logic [31:0] rdata_o,
  output logic        enable_o,
  output logic        cursor_on_o,
  output logic        cfg_stb_o,
  output logic        sync_stb_o,
  output logic        bad_index_o,
  output logic        depth_err_o
);
  localparam int unsigned SCR_AW = (SCR_N > 1) ? $clog2(SCR_N) : 1;
  localparam int unsigned BYPP   = (DEPTH + 7) / 8;
  localparam int unsigned BPP    = BYPP * 8;

  logic [IDX_W-1:0]  idx_q;
  logic [31:0]       id_q;
  logic              en_q, cfg_q;
  logic [DIM_W-1:0]  w_q, h_q;
  kind_e             kind;
  logic [SCR_AW-1:0] scr_off;
  logic [31:0]       scr_rdata, cid, cx, cy, val_rd;
  logic              wr_val, rd_val, id_ok;

  assign wr_val = wr_i && port_i == PORT_VAL;
  assign rd_val = rd_i && port_i == PORT_VAL;
  assign id_ok  = wdata_i == ID_V0 || wdata_i == ID_V1 || wdata_i == ID_V2;

  dreg_decode #(.IDX_W(IDX_W), .SCR_N(SCR_N), .SCR_AW(SCR_AW)) i_decode (
    .idx_i(idx_q), .kind_o(kind), .scr_off_o(scr_off)
  );

  dreg_scratch #(.N(SCR_N), .AW(SCR_AW), .DW(32)) i_scratch (
    .clk_i, .rst_ni, .we_i(wr_val && kind == K_SCR), .off_i(scr_off),
    .wdata_i, .rdata_o(scr_rdata)
  );

  dreg_cursor i_cursor (
    .clk_i, .rst_ni,
    .we_id_i(wr_val && kind == K_CID), .we_x_i(wr_val && kind == K_CX),
    .we_y_i(wr_val && kind == K_CY),   .we_on_i(wr_val && kind == K_CON),
    .wdata_i, .id_o(cid), .x_o(cx), .y_o(cy), .on_o(cursor_on_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      id_q        <= ID_V2;
      en_q        <= 1'b0;
      cfg_q       <= 1'b0;
      w_q         <= '0;
      h_q         <= '0;
      cfg_stb_o   <= 1'b0;
      sync_stb_o  <= 1'b0;
      bad_index_o <= 1'b0;
      depth_err_o <= 1'b0;
    end else begin
      cfg_stb_o   <= wr_val && kind == K_CFG;
      sync_stb_o  <= wr_val && kind == K_SYNC;
      bad_index_o <= (wr_val || rd_val) && kind == K_BAD;
      depth_err_o <= wr_val && kind == K_BPP && wdata_i != 32'(DEPTH);
      if (wr_i && port_i == PORT_IDX) idx_q <= wdata_i[IDX_W-1:0];
      if (wr_val) begin
        case (kind)
          K_ID:  if (id_ok) id_q <= wdata_i;
          K_EN: begin
            en_q  <= wdata_i[0] & cfg_q;
            cfg_q <= wdata_i[0] & cfg_q;
          end
          K_CFG: cfg_q <= wdata_i[0];
          K_W:   w_q   <= wdata_i[DIM_W-1:0];
          K_H:   h_q   <= wdata_i[DIM_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (kind)
      K_ID:    val_rd = id_q;
      K_EN:    val_rd = 32'(en_q);
      K_W:     val_rd = 32'(w_q);
      K_H:     val_rd = 32'(h_q);
      K_MAXW:  val_rd = 32'(MAX_W);
      K_MAXH:  val_rd = 32'(MAX_H);
      K_DEPTH: val_rd = 32'(DEPTH);
      K_BPP,
      K_HBPP:  val_rd = 32'(BPP);
      K_BPL:   val_rd = 32'(BYPP) * 32'(w_q);
      K_VRAM:  val_rd = 32'(VRAM_BYTES - FIFO_BYTES);
      K_CAPS:  val_rd = {30'd0, CAP_COPY, CAP_FILL};
      K_FIFO:  val_rd = 32'(FIFO_BYTES);
      K_CFG:   val_rd = 32'(cfg_q);
      K_BUSY:  val_rd = 32'(!engine_idle_i);
      K_CID:   val_rd = cid;
      K_CX:    val_rd = cx;
      K_CY:    val_rd = cy;
      K_CON:   val_rd = 32'(cursor_on_o);
      K_SCRN:  val_rd = 32'(SCR_N);
      K_SCR:   val_rd = scr_rdata;
      default: val_rd = '0;
    endcase
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (port_i == PORT_IDX)      rdata_o = 32'(idx_q);
      else if (port_i == PORT_VAL) rdata_o = val_rd;
    end
  end

  assign enable_o = en_q;

  a_r2_id_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_q == ID_V0 || id_q == ID_V1 || id_q == ID_V2);
  a_r3_en_rise_needs_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> $past(cfg_q));
  a_r4_cfg_stb_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_stb_o |-> $past(wr_i && port_i == PORT_VAL && 32'(idx_q) == IX_CFG));
  a_r4_sync_stb_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_stb_o |-> $past(wr_i && port_i == PORT_VAL && 32'(idx_q) == IX_SYNC));
  a_r7_err_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_err_o |-> $past(wr_i && wdata_i != 32'(DEPTH)));
  a_r12_bad_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_index_o |-> $past((rd_i || wr_i) && port_i == PORT_VAL));
endmodule

// File: tb/test_dispctl_regfile.sv
module test_dispctl_regfile;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, idle = 1'b1;
  logic [1:0]  port = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic        en_o, con_o, cstb, sstb, bad, derr;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dispctl_regfile i_dispctl_regfile (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .port_i(port),
    .wdata_i(wdata), .engine_idle_i(idle), .rdata_o(rdata), .enable_o(en_o),
    .cursor_on_o(con_o), .cfg_stb_o(cstb), .sync_stb_o(sstb),
    .bad_index_o(bad), .depth_err_o(derr)
  );

  // reference model state
  int unsigned m_idx = 0;
  logic [31:0] m_id = 32'h9000_0002, m_cid = 0, m_cx = 0, m_cy = 0;
  logic [31:0] m_scr [16];
  int unsigned m_w = 0, m_h = 0;
  bit m_en = 0, m_cfg = 0, m_con = 0, m_cs = 0, m_ss = 0, m_bad = 0, m_derr = 0;

  function automatic bit is_bad(int unsigned i);
    if (i <= 7 || i == 12 || i == 15 || i == 17) return 0;
    if (i >= 19 && i <= 22) return 0;
    if (i >= 24 && i <= 32) return 0;
    if (i >= 1024 && i < 1792 + 16) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] m_read(int unsigned i);
    case (i)
      0: return m_id;          1: return 32'(m_en);
      2: return m_w;           3: return m_h;
      4: return 2360;          5: return 1770;
      6: return 24;            7: return 24;
      12: return 3 * m_w;      15: return 32'h0100_0000 - 32'h1_0000;
      17: return 3;            19: return 32'h1_0000;
      20: return 32'(m_cfg);   22: return 32'(!idle);
      24: return m_cid;        25: return m_cx;
      26: return m_cy;         27: return 32'(m_con);
      28: return 24;           29: return 16;
      default: begin
        if (i >= 1792 && i < 1808) return m_scr[i - 1792];
        return 0;
      end
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(logic [1:0] p, bit w, bit r, logic [31:0] d, string tag);
    logic [31:0] er;
    port = p; wr = w; rd = r; wdata = d;
    #1;
    er = 0;
    if (r) er = (p == 0) ? 32'(m_idx) : (p == 1) ? m_read(m_idx) : 32'd0;
    chk(tag, rdata, er);
    chk("R3 enable_o", 32'(en_o), 32'(m_en));
    chk("R8 cursor_on_o", 32'(con_o), 32'(m_con));
    chk("R4 cfg_stb_o", 32'(cstb), 32'(m_cs));
    chk("R4 sync_stb_o", 32'(sstb), 32'(m_ss));
    chk("R12 bad_index_o", 32'(bad), 32'(m_bad));
    chk("R7 depth_err_o", 32'(derr), 32'(m_derr));
    @(posedge clk);
    m_cs = 0; m_ss = 0; m_derr = 0;
    m_bad = (p == 1) && (w || r) && is_bad(m_idx);
    if (w && p == 0) m_idx = d & 32'hFFFF;
    else if (w && p == 1) begin
      case (m_idx)
        0: if (d == 32'h9000_0000 || d == 32'h9000_0001 || d == 32'h9000_0002) m_id = d;
        1: begin m_en = d[0] & m_cfg; m_cfg = m_en; end
        2: m_w = d & 32'hFFFF;
        3: m_h = d & 32'hFFFF;
        7: m_derr = (d != 24);
        20: begin m_cfg = d[0]; m_cs = 1; end
        21: m_ss = 1;
        24: m_cid = d;  25: m_cx = d;  26: m_cy = d;
        27: if (d == 1) m_con = 1; else if (d == 0) m_con = 0;
        default: if (m_idx >= 1792 && m_idx < 1808) m_scr[m_idx - 1792] = d;
      endcase
    end
    @(negedge clk);
    wr = 0; rd = 0;
  endtask

  task automatic wreg(int unsigned i, logic [31:0] d, string tag);
    acc(2'd0, 1, 0, i, tag);
    acc(2'd1, 1, 0, d, tag);
    acc(2'd1, 0, 1, 0, tag);
  endtask

  task automatic rreg(int unsigned i, string tag);
    acc(2'd0, 1, 0, i, tag);
    acc(2'd1, 0, 1, 0, tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) m_scr[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    acc(2'd1, 0, 1, 0, "R2 reset id");
    // R1 index and auxiliary ports
    acc(2'd0, 1, 0, 32'hABCD_0003, "R1 idx write");
    acc(2'd0, 0, 1, 0, "R1 idx readback");
    acc(2'd2, 1, 0, 32'hFFFF_FFFF, "R1 aux write");
    acc(2'd2, 0, 1, 0, "R1 aux read");
    acc(2'd0, 0, 1, 0, "R1 idx kept");
    // R2 identity
    wreg(0, 32'h1234_5678, "R2 bad id");
    wreg(0, 32'h9000_0003, "R2 near id");
    wreg(0, 32'h9000_0000, "R2 id0");
    wreg(0, 32'h9000_0001, "R2 id1");
    // R3/R4 handshake
    wreg(1, 1, "R3 enable before cfg");
    wreg(20, 1, "R4 cfg done");
    wreg(1, 3, "R3 enable with cfg");
    wreg(1, 2, "R3 enable bit0 clear");
    rreg(20, "R3 cfg dropped");
    wreg(20, 1, "R4 cfg again");
    wreg(1, 1, "R3 enable set");
    wreg(21, 5, "R4 sync");
    // R5 busy
    idle = 1'b0; rreg(22, "R5 busy");
    idle = 1'b1; rreg(22, "R5 idle");
    // R6 mode
    wreg(2, 32'h0001_0280, "R6 width");
    wreg(3, 480, "R6 height");
    rreg(12, "R6 bytes per line");
    rreg(7, "R6 bpp");
    rreg(28, "R6 host bpp");
    // R7 depth
    wreg(7, 16, "R7 wrong depth");
    wreg(7, 24, "R7 right depth");
    // R8 cursor visibility
    wreg(27, 1, "R8 show");
    wreg(27, 2, "R8 code2 keeps");
    wreg(27, 3, "R8 code3 keeps");
    wreg(27, 0, "R8 hide");
    wreg(27, 3, "R8 code3 keeps off");
    // R13 cursor regs
    wreg(24, 32'hDEAD_BEEF, "R13 cursor id");
    wreg(25, 640, "R13 cursor x");
    wreg(26, 32'h8000_0001, "R13 cursor y");
    // R9 constants
    for (int i = 4; i <= 6; i++) wreg(i, 7, "R9 const");
    wreg(15, 1, "R9 vram");
    wreg(17, 0, "R9 caps");
    wreg(19, 0, "R9 fifo");
    rreg(29, "R9 scratch count");
    // R10 zero ranges
    wreg(1024, 32'h55, "R10 palette lo");
    wreg(1791, 32'h55, "R10 palette hi");
    wreg(30, 9, "R10 reserved");
    wreg(32, 9, "R10 reserved hi");
    // R11 scratch
    wreg(1792, 32'hCAFE_0000, "R11 scratch first");
    wreg(1807, 32'hCAFE_000F, "R11 scratch last");
    rreg(1792, "R11 scratch first kept");
    // R12 undefined
    wreg(1808, 32'h1111, "R12 past scratch");
    wreg(8, 32'h2222, "R12 idx8");
    wreg(23, 32'h3333, "R12 idx23");
    rreg(1023, "R12 idx1023");
    rreg(1807, "R12 scratch untouched");
    rreg(0, "R2 id final");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule